// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This controller drives a scan chain that has been cut into several equal segments, so that during shifting only one segment is clocked at a time. It produces one clock enable per segment and routes the serial scan input to the active segment. It also selects that segment's serial output onto the scan output. Every other segment keeps its contents, which keeps switching in the scan cells and in the logic they feed low.

The controller works through the segments in ascending order. Each segment takes a fixed number of shift strobes, during which its old contents are unloaded and new data is loaded. After the last bit of the last segment, a pattern-complete pulse is raised and the pointer wraps back to segment 0.

When scan enable falls, every segment is enabled for exactly one cycle. Cells that depend on each other therefore all capture their responses in the same cycle. The segment count and segment length are parameters.

Top module: `sscan_ctrl`

## Requirements
- R1: While reset is asserted, all segment enables and the pattern-complete pulse are low. After reset, the first shift strobe enables segment 0.
- R2: In a cycle with scan_en high and shift_stb high, exactly one bit of seg_clk_en is high: the bit of the active segment.
- R3: In a cycle with scan_en high and shift_stb low, all of seg_clk_en is low, so every segment holds its data.
- R4: During a shift, seg_si of the active segment equals scan_in and seg_si of every other segment is 0.
- R5: During a shift, scan_out equals seg_so of the active segment, so the chain unloads in the same order it was loaded.
- R6: After SEG_LEN shift strobes on one segment, the next strobe enables the segment with the next higher index. Strobes do not need to be consecutive.
- R7: The cycle after the final strobe of the highest segment, pattern_done is high for exactly one cycle, and the next strobe enables segment 0 again.
- R8: In the first cycle with scan_en low after a cycle with it high, all bits of seg_clk_en are high (capture). In later cycles with scan_en low, all bits are low.
- R9: A capture cycle returns the pointer to segment 0 and clears the bit count. A shift_stb in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High for shift mode; its falling edge starts a capture |
| shift_stb | input | 1 | Moves one bit per cycle when high in shift mode |
| scan_in | input | 1 | Serial data from the tester |
| seg_so | input | NSEG | Serial output of each segment |
| seg_clk_en | output | NSEG | Clock enable for each segment |
| seg_si | output | NSEG | Serial input for each segment |
| scan_out | output | 1 | Serial output selected from the active segment |
| pattern_done | output | 1 | One-cycle pulse after the last bit of the last segment |

## Verification
A shift strobe and a capture can land in the same cycle when scan enable falls while a strobe is still high. The bench provokes this after a partial load that has the bit count part way through segment 1. It judges the result by requiring every enable in that cycle and by requiring the next strobe to enable segment 0. It then counts a full 32 further strobes before the pattern-complete pulse appears. Because the bench models the segments as shift registers that invert their contents on capture, unloading after a capture also shows at scan_out that every segment took part.

// File: rtl/sscan_pkg.sv
package sscan_pkg;

    // Operating mode decided once per cycle
    typedef enum logic [1:0] {
        SM_HOLD    = 2'd0,
        SM_SHIFT   = 2'd1,
        SM_CAPTURE = 2'd2
    } scan_mode_e;

    // Width of a counter that holds 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sscan_mode_dec.sv
module sscan_mode_dec
    import sscan_pkg::*;
(
    input  logic       scan_en,
    input  logic       se_prev,
    input  logic       shift_stb,
    output scan_mode_e mode
);

    always_comb begin
        if (!scan_en && se_prev) begin
            mode = SM_CAPTURE;          // falling edge of scan enable wins
        end else if (scan_en && shift_stb) begin
            mode = SM_SHIFT;
        end else begin
            mode = SM_HOLD;
        end
    end

endmodule

// File: rtl/sscan_step.sv
module sscan_step #(
    parameter int NSEG    = 4,
    parameter int SEG_LEN = 8,
    parameter int CW      = 3
) (
    input  logic [NSEG-1:0] ptr_q,
    input  logic [CW-1:0]   cnt_q,
    output logic [NSEG-1:0] ptr_adv,
    output logic [CW-1:0]   cnt_adv,
    output logic            wrap
);

    localparam logic [CW-1:0] LAST_CNT = CW'(SEG_LEN - 1);

    logic [NSEG-1:0] ptr_rot;

    generate
        if (NSEG == 1) begin : g_single
            assign ptr_rot = ptr_q;
        end else begin : g_ring
            assign ptr_rot = {ptr_q[NSEG-2:0], ptr_q[NSEG-1]};
        end
    endgenerate

    always_comb begin
        if (cnt_q == LAST_CNT) begin
            cnt_adv = '0;
            ptr_adv = ptr_rot;
            wrap    = ptr_q[NSEG-1];
        end else begin
            cnt_adv = cnt_q + CW'(1);
            ptr_adv = ptr_q;
            wrap    = 1'b0;
        end
    end

endmodule

// File: rtl/sscan_route.sv
module sscan_route
    import sscan_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  scan_mode_e      mode,
    input  logic [NSEG-1:0] ptr_q,
    input  logic            scan_in,
    input  logic [NSEG-1:0] seg_so,
    output logic [NSEG-1:0] seg_clk_en,
    output logic [NSEG-1:0] seg_si,
    output logic            scan_out
);

    generate
        for (genvar i = 0; i < NSEG; i++) begin : g_seg
            assign seg_clk_en[i] = (mode == SM_CAPTURE) ||
                                   ((mode == SM_SHIFT) && ptr_q[i]);
            assign seg_si[i]     = scan_in && ptr_q[i];
        end
    endgenerate

    // Bypass output mux: one-hot select of the active segment
    always_comb begin
        scan_out = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            scan_out = scan_out | (ptr_q[i] & seg_so[i]);
        end
    end

endmodule

// File: rtl/sscan_ctrl.sv
module sscan_ctrl
    import sscan_pkg::*;
#(
    parameter int NSEG    = 4,
    parameter int SEG_LEN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_en,
    input  logic            shift_stb,
    input  logic            scan_in,
    input  logic [NSEG-1:0] seg_so,
    output logic [NSEG-1:0] seg_clk_en,
    output logic [NSEG-1:0] seg_si,
    output logic            scan_out,
    output logic            pattern_done
);

    localparam int CW = cnt_width(SEG_LEN);
    localparam logic [NSEG-1:0] FIRST_SEG = NSEG'(1);

    typedef struct packed {
        logic [NSEG-1:0] ptr;
        logic [CW-1:0]   cnt;
        logic            done;
        logic            se_prev;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;
    scan_mode_e  mode;
    logic [NSEG-1:0] ptr_adv;
    logic [CW-1:0]   cnt_adv;
    logic            wrap;

    sscan_mode_dec u_mode (
        .scan_en   (scan_en),
        .se_prev   (state_q.se_prev),
        .shift_stb (shift_stb),
        .mode      (mode)
    );

    sscan_step #(
        .NSEG    (NSEG),
        .SEG_LEN (SEG_LEN),
        .CW      (CW)
    ) u_step (
        .ptr_q   (state_q.ptr),
        .cnt_q   (state_q.cnt),
        .ptr_adv (ptr_adv),
        .cnt_adv (cnt_adv),
        .wrap    (wrap)
    );

    sscan_route #(
        .NSEG (NSEG)
    ) u_route (
        .mode       (mode),
        .ptr_q      (state_q.ptr),
        .scan_in    (scan_in),
        .seg_so     (seg_so),
        .seg_clk_en (seg_clk_en),
        .seg_si     (seg_si),
        .scan_out   (scan_out)
    );

    always_comb begin
        state_d         = state_q;
        state_d.done    = 1'b0;
        state_d.se_prev = scan_en;
        unique case (mode)
            SM_SHIFT: begin
                state_d.ptr  = ptr_adv;
                state_d.cnt  = cnt_adv;
                state_d.done = wrap;
            end
            SM_CAPTURE: begin
                state_d.ptr = FIRST_SEG;
                state_d.cnt = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ptr     <= FIRST_SEG;
            state_q.cnt     <= '0;
            state_q.done    <= 1'b0;
            state_q.se_prev <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pattern_done = state_q.done;

endmodule

// File: rtl/sscan_ctrl_chk.sv
module sscan_ctrl_chk #(
    parameter int NSEG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scan_en,
    input logic            shift_stb,
    input logic            scan_in,
    input logic [NSEG-1:0] seg_so,
    input logic [NSEG-1:0] seg_clk_en,
    input logic [NSEG-1:0] seg_si,
    input logic            scan_out,
    input logic            pattern_done
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_one_shift_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && shift_stb) |-> ($countones(seg_clk_en) == 1));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !shift_stb) |-> (seg_clk_en == '0));

    assert_si_routed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && shift_stb) |->
            (((seg_si & ~seg_clk_en) == '0) && ((|(seg_si & seg_clk_en)) == scan_in)));

    assert_so_routed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && shift_stb) |-> (scan_out == (|(seg_so & seg_clk_en))));

    assert_done_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pattern_done) |-> $past(scan_en && shift_stb));

    assert_capture_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !scan_en && $past(scan_en)) |-> (&seg_clk_en));

    assert_capture_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !scan_en && !$past(scan_en)) |-> (seg_clk_en == '0));

endmodule

bind sscan_ctrl sscan_ctrl_chk #(.NSEG(NSEG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_en      (scan_en),
    .shift_stb    (shift_stb),
    .scan_in      (scan_in),
    .seg_so       (seg_so),
    .seg_clk_en   (seg_clk_en),
    .seg_si       (seg_si),
    .scan_out     (scan_out),
    .pattern_done (pattern_done)
);

// File: tb/sscan_ctrl_bench.sv
module sscan_ctrl_bench;

    localparam int NSEG    = 4;
    localparam int SEG_LEN = 8;
    localparam int TOTAL   = NSEG * SEG_LEN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scan_en = 1'b0;
    logic            shift_stb = 1'b0;
    logic            scan_in = 1'b0;
    logic [NSEG-1:0] seg_so;
    logic [NSEG-1:0] seg_clk_en;
    logic [NSEG-1:0] seg_si;
    logic            scan_out;
    logic            pattern_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sscan_ctrl #(.NSEG(NSEG), .SEG_LEN(SEG_LEN)) u_sscan_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_en      (scan_en),
        .shift_stb    (shift_stb),
        .scan_in      (scan_in),
        .seg_so       (seg_so),
        .seg_clk_en   (seg_clk_en),
        .seg_si       (seg_si),
        .scan_out     (scan_out),
        .pattern_done (pattern_done)
    );

    // Segment model: shift when enabled in scan mode, invert on capture
    logic [SEG_LEN-1:0] segm [NSEG];
    always_ff @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < NSEG; i++) begin
            if (!rst_n)             segm[i] <= '0;
            else if (seg_clk_en[i]) segm[i] <= scan_en ?
                                        {segm[i][SEG_LEN-2:0], seg_si[i]} : ~segm[i];
        end
    end
    always_comb begin
        for (int i = 0; i < NSEG; i++) seg_so[i] = segm[i][SEG_LEN-1];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NSEG-1:0] onehot(input int s);
        logic [NSEG-1:0] v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    task automatic shift_bit(input logic b, input int exp_seg, input bit chk_out,
                             input logic exp_out, input logic exp_done, input bit gap);
        @(negedge clk);
        scan_en = 1'b1; shift_stb = 1'b1; scan_in = b;
        #1;
        check("R2 R6 active enable", 32'(seg_clk_en), 32'(onehot(exp_seg)));
        check("R4 seg_si routing", 32'(seg_si), b ? 32'(onehot(exp_seg)) : 32'd0);
        if (chk_out) check("R5 scan_out", 32'(scan_out), 32'(exp_out));
        check("R7 done timing", 32'(pattern_done), 32'(exp_done));
        @(posedge clk);
        if (gap) begin
            @(negedge clk);
            shift_stb = 1'b0;
            #1;
            check("R3 hold when idle", 32'(seg_clk_en), 32'd0);
            @(posedge clk);
        end
    endtask

    task automatic idle_check_done(input logic exp_done);
        @(negedge clk);
        shift_stb = 1'b0; scan_en = 1'b1;
        #1;
        check("R7 done pulse", 32'(pattern_done), 32'(exp_done));
        check("R3 idle enables", 32'(seg_clk_en), 32'd0);
        @(posedge clk);
    endtask

    task automatic apply_reset;
        @(negedge clk);
        rst_n = 1'b0; scan_en = 1'b0; shift_stb = 1'b0; scan_in = 1'b0;
        #1;
        check("R1 reset enables", 32'(seg_clk_en), 32'd0);
        check("R1 reset done", 32'(pattern_done), 32'd0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
    endtask

    // Full pattern loads, then a second pattern unloads the first
    task automatic test_load_unload;
        logic [TOTAL-1:0] pa = TOTAL'(64'hC3A5_1E7B_96F0_2D4C);
        logic [TOTAL-1:0] pb = TOTAL'(64'h5A0F_E1C3_7B29_D486);
        apply_reset();
        for (int k = 0; k < TOTAL; k++) shift_bit(pa[k], k / SEG_LEN, 1'b0, 1'b0, 1'b0, 1'b0);
        idle_check_done(1'b1);
        idle_check_done(1'b0);
        for (int k = 0; k < TOTAL; k++) shift_bit(pb[k], k / SEG_LEN, 1'b1, pa[k], 1'b0, 1'b0);
        idle_check_done(1'b1);
        // back-to-back patterns: done is visible during first strobe of the next one
        for (int k = 0; k < TOTAL; k++) shift_bit(pa[k], k / SEG_LEN, 1'b1, pb[k], 1'b0, 1'b0);
        shift_bit(1'b0, 0, 1'b1, pa[0], 1'b1, 1'b0);
    endtask

    // Strobes with idle gaps: segments hold, unload still matches (R3, R6)
    task automatic test_gaps;
        logic [TOTAL-1:0] pc = TOTAL'(64'h0123_4567_89AB_CDEF);
        logic [TOTAL-1:0] pd = TOTAL'(64'hFEDC_BA98_7654_3210);
        apply_reset();
        for (int k = 0; k < TOTAL; k++) shift_bit(pc[k], k / SEG_LEN, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < TOTAL; k++) shift_bit(pd[k], k / SEG_LEN, 1'b1, pc[k], 1'b0, 1'b0);
        idle_check_done(1'b1);
    endtask

    // Capture enables all segments once; unload shows inverted data (R8, R9)
    task automatic test_capture;
        logic [TOTAL-1:0] pe = TOTAL'(64'h9E37_79B9_7F4A_7C15);
        logic [TOTAL-1:0] pf = TOTAL'(64'h1357_9BDF_2468_ACE0);
        apply_reset();
        for (int k = 0; k < TOTAL; k++) shift_bit(pe[k], k / SEG_LEN, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        scan_en = 1'b0; shift_stb = 1'b0;
        #1;
        check("R8 capture all enabled", 32'(seg_clk_en), 32'(onehot(0) * 0 + {NSEG{1'b1}}));
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R8 single capture cycle", 32'(seg_clk_en), 32'd0);
        @(posedge clk);
        for (int k = 0; k < TOTAL; k++) shift_bit(pf[k], k / SEG_LEN, 1'b1, ~pe[k], 1'b0, 1'b0);
        idle_check_done(1'b1);
    endtask

    // Strobe coincides with capture mid-pattern; pointer and count clear (R9)
    task automatic test_capture_mid;
        apply_reset();
        for (int k = 0; k < 10; k++) shift_bit(k[0], k / SEG_LEN, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        scan_en = 1'b0; shift_stb = 1'b1;
        #1;
        check("R9 capture beats strobe", 32'(seg_clk_en), 32'({NSEG{1'b1}}));
        @(posedge clk);
        for (int k = 0; k < TOTAL; k++) shift_bit(1'b1, k / SEG_LEN, 1'b0, 1'b0, 1'b0, 1'b0);
        idle_check_done(1'b1);
    endtask

    // Reset in the middle of a pattern returns to segment 0 (R1)
    task automatic test_reset_mid;
        apply_reset();
        for (int k = 0; k < 13; k++) shift_bit(1'b1, k / SEG_LEN, 1'b0, 1'b0, 1'b0, 1'b0);
        apply_reset();
        shift_bit(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        test_load_unload();
        test_gaps();
        test_capture();
        test_capture_mid();
        test_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule